// File: doc/BRIEF.md
# Hold-off Gated Load Pulse Generator

This block watches a conversion-complete input and a line-valid input, both sampled on the pixel clock. When the conversion-complete input goes from low to high, the block records a pending request. It then answers that request with a single-cycle load strobe. The strobe is not issued until both inputs have been quiet long enough.

Each input has its own hold-off counter. The counter restarts whenever its input changes level and counts up to a parameterised hold-off value. The strobe goes out only when all of the following hold: a request is pending, conversion-complete is high, line-valid is low, and both hold-offs have expired. Every transition is found by comparing the sampled level with a registered copy from the previous cycle. Neither input ever drives a clock pin. An optional synchronizer chain can be placed ahead of each edge register.

Top module: `holdoff_load_pulser`

## Requirements
- R1: While `rst` is high at a clock edge, `load_o` is 0 after that edge and any pending request is dropped. After reset is released, a strobe needs a new low-to-high transition of `conv_done_i`.
- R2: A request is made only by a low-to-high change of `conv_done_i` between two consecutive clock samples. Holding `conv_done_i` high yields no further strobe.
- R3: Suppose `conv_done_i` is first sampled high at clock edge t, and `line_valid_i` has been low and unchanged since edge t-HOLD or earlier. Then `load_o` is 1 exactly after edge t+HOLD+1, with HOLD = 4 by default.
- R4: Each strobe on `load_o` lasts exactly one clock cycle, and issuing it clears the pending request.
- R5: Any level change of `line_valid_i` restarts its hold-off. If `line_valid_i` is sampled with a new low level at edge s, no strobe occurs before edge s+HOLD+1.
- R6: While `line_valid_i` is high, no strobe is issued, but the request stays pending. Once `line_valid_i` falls, the strobe follows under R5.
- R7: If `conv_done_i` falls while a request is pending, the request is cancelled and no strobe is issued.
- R8: When both inputs change near each other, the strobe comes at the first edge n at which all of these hold: n minus the last `conv_done_i` change is at least HOLD+1, n minus the last `line_valid_i` change is at least HOLD+1, a request is pending, `conv_done_i` is high and `line_valid_i` is low.
- R9: The hold-off counters saturate at HOLD and never wrap. A request that arrives after an arbitrarily long quiet period still gets its strobe at t+HOLD+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| conv_done_i | input | 1 | Conversion-complete level; a rising transition raises a request |
| line_valid_i | input | 1 | Line-valid level; must be low and settled for a strobe |
| load_o | output | 1 | Single-cycle load strobe |

## Verification
Two events can fall on the same clock edge: the expiry of the conversion hold-off, which would release the strobe, and a fresh `line_valid_i` transition, which must restart the other hold-off and hold the strobe back. The bench provokes this overlap by sweeping the offset of the `line_valid_i` fall from several cycles before to several cycles after the `conv_done_i` rise. A pseudo-random toggle run adds further overlaps. Each cycle is judged against a reference that is computed from the distances, in edges, back to the last change of each input. The bench also checks the exact cycle of the first strobe and the number of strobes arithmetically.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    // Sampled level of one input plus its transition strobes for this cycle
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    // Registered state of the request/strobe controller
    typedef struct packed {
        logic pend;
        logic load;
    } ctrl_t;

    // Counter width able to hold the value 0..hold
    function automatic int unsigned cnt_width(input int unsigned hold);
        return (hold < 2) ? 1 : $clog2(hold + 1);
    endfunction

endpackage

// File: rtl/lpg_edge.sv
module lpg_edge
    import lpg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw_i,
    output edge_t ev_o
);

    logic lvl;

    // Optional synchronizer chain ahead of the edge register
    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign lvl = raw_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sh_d, sh_q;

            always_comb begin
                sh_d[0] = raw_i;
                for (int i = 1; i < SYNC_STAGES; i++) begin
                    sh_d[i] = sh_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= sh_d;
            end

            assign lvl = sh_q[SYNC_STAGES-1];
        end
    endgenerate

    // Previous-cycle copy used for transition detection
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    always_comb begin
        ev_o.level = lvl;
        ev_o.rise  = lvl & ~prev_q;
        ev_o.fall  = ~lvl & prev_q;
    end

    // R2: a rise strobe never lasts two cycles in a row
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        ev_o.rise |=> !ev_o.rise);

endmodule

// File: rtl/lpg_holdoff.sv
module lpg_holdoff
    import lpg_pkg::*;
#(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic expired_o
);

    localparam int unsigned CW = cnt_width(HOLD);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i) begin
            cnt_d = '0;
        end else if (cnt_q < LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= LIMIT);

    // R9: counter never passes the hold-off value
    assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R9: once expired, stays expired until the next restart
    assert_hold_expired_R9: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !restart_i) |=> expired_o);

    // R5: a restart always re-arms the hold-off
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !expired_o);

endmodule

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
    import lpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  edge_t done_ev_i,
    input  edge_t lv_ev_i,
    input  logic  done_ok_i,
    input  logic  lv_ok_i,
    output logic  load_o,
    output logic  pend_o
);

    ctrl_t st_d, st_q;
    logic  fire;

    always_comb begin
        // A line-valid fall in this very cycle restarts its hold-off: block it
        fire = st_q.pend & done_ev_i.level & ~lv_ev_i.level
             & done_ok_i & lv_ok_i & ~lv_ev_i.fall;

        st_d = st_q;
        st_d.load = fire;
        if (done_ev_i.rise) begin
            st_d.pend = 1'b1;
        end else if (done_ev_i.fall || fire) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load_o = st_q.load;
    assign pend_o = st_q.pend;

    // R4: strobe is exactly one cycle wide
    assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.load |=> !st_q.load);

    // R4: issuing the strobe leaves no request pending
    assert_clear_pend_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.load |-> !st_q.pend);

endmodule

// File: rtl/holdoff_load_pulser.sv
module holdoff_load_pulser
    import lpg_pkg::*;
#(
    parameter int unsigned HOLD        = 4,
    parameter int unsigned SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_done_i,
    input  logic line_valid_i,
    output logic load_o
);

    edge_t done_ev, lv_ev;
    logic  done_ok, lv_ok, pend;

    lpg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_done_edge (
        .clk   (clk),
        .rst   (rst),
        .raw_i (conv_done_i),
        .ev_o  (done_ev)
    );

    lpg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_lv_edge (
        .clk   (clk),
        .rst   (rst),
        .raw_i (line_valid_i),
        .ev_o  (lv_ev)
    );

    // Conversion hold-off restarts on both directions
    lpg_holdoff #(.HOLD(HOLD)) u_done_hold (
        .clk       (clk),
        .rst       (rst),
        .restart_i (done_ev.rise | done_ev.fall),
        .expired_o (done_ok)
    );

    // Line-valid hold-off restarts on both directions
    lpg_holdoff #(.HOLD(HOLD)) u_lv_hold (
        .clk       (clk),
        .rst       (rst),
        .restart_i (lv_ev.rise | lv_ev.fall),
        .expired_o (lv_ok)
    );

    lpg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .done_ev_i (done_ev),
        .lv_ev_i   (lv_ev),
        .done_ok_i (done_ok),
        .lv_ok_i   (lv_ok),
        .load_o    (load_o),
        .pend_o    (pend)
    );

    // R6: a strobe follows only a cycle with line-valid low
    assert_lv_low_R6: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $past(!lv_ev.level));

    // R3: a strobe follows only a cycle with conversion-complete high
    assert_done_high_R3: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $past(done_ev.level));

    // R7: a conversion-complete fall cancels any strobe in the next cycle
    assert_cancel_R7: assert property (@(posedge clk) disable iff (rst)
        done_ev.fall |=> (!load_o && !pend));

    // R5: no strobe right after a line-valid transition
    assert_lv_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (lv_ev.rise || lv_ev.fall) |=> !load_o);

endmodule

// File: tb/holdoff_load_pulser_test.sv
module holdoff_load_pulser_test;

    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done_in = 1'b0;
    logic lv_in = 1'b0;
    logic load;

    always #4 clk = ~clk;   // 125 MHz

    holdoff_load_pulser #(.HOLD(HOLD), .SYNC_STAGES(0)) uut (
        .clk          (clk),
        .rst          (rst),
        .conv_done_i  (done_in),
        .line_valid_i (lv_in),
        .load_o       (load)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    string tag    = "R1";

    // Reference model state (distance-based)
    int m_last_d = 0, m_last_l = 0;
    bit m_prev_d = 0, m_prev_l = 0, m_pend = 0, m_load = 0;

    int pulses = 0, run = 0, maxrun = 0;
    int first_pulse = -1, rise_cyc = -1, lvfall_cyc = -1;

    task automatic check_bit(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: load_o got %b expected %b", req, cyc, got, exp);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(input logic d, input logic l);
        bit fire;
        done_in = d;
        lv_in   = l;
        @(posedge clk);
        cyc++;
        if (rst) begin
            m_prev_d = 0; m_prev_l = 0; m_pend = 0; m_load = 0;
            m_last_d = cyc; m_last_l = cyc;
        end else begin
            if (d != m_prev_d) m_last_d = cyc;
            if (l != m_prev_l) m_last_l = cyc;
            if (d && !m_prev_d) rise_cyc = cyc;
            if (!l && m_prev_l) lvfall_cyc = cyc;
            fire = m_pend && d && !l
                && (cyc - m_last_d >= HOLD + 1) && (cyc - m_last_l >= HOLD + 1);
            m_load = fire;
            if (d && !m_prev_d)              m_pend = 1;
            else if ((!d && m_prev_d) || fire) m_pend = 0;
            m_prev_d = d;
            m_prev_l = l;
        end
        @(negedge clk);
        check_bit(tag, load, m_load);
        if (load === 1'b1) begin
            pulses++;
            run++;
            if (run > maxrun) maxrun = run;
            if (first_pulse < 0) first_pulse = cyc;
        end else begin
            run = 0;
        end
    endtask

    task automatic clear_stats();
        pulses = 0; maxrun = 0; run = 0; first_pulse = -1;
    endtask

    task automatic idle(input int n, input logic l);
        for (int i = 0; i < n; i++) step(1'b0, l);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        logic d, l;

        // R1: reset state
        tag = "R1";
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        rst = 1'b0;
        idle(8, 1'b0);

        // R3 / R4: basic request with quiet line-valid
        tag = "R3"; clear_stats();
        for (int i = 0; i < 14; i++) step(1'b1, 1'b0);
        check_int("R3", first_pulse - rise_cyc, HOLD + 1);
        check_int("R4", pulses, 1);
        check_int("R4", maxrun, 1);
        idle(8, 1'b0);

        // R2: held high gives one strobe; a fresh rise gives another
        tag = "R2"; clear_stats();
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        check_int("R2", pulses, 1);
        idle(3, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        check_int("R2", pulses, 2);
        idle(8, 1'b0);

        // R8: sweep line-valid fall offset around the conversion rise
        tag = "R8";
        for (int off = -5; off <= 8; off++) begin
            idle(8, 1'b1);
            clear_stats();
            for (int k = 0; k < 26; k++) step(k >= 6, k < 6 + off);
            check_int("R8", pulses, 1);
            check_int("R8", first_pulse - ((off > 0) ? 6 + off : 6) - (rise_cyc - 6 - (rise_cyc - rise_cyc)) + rise_cyc - rise_cyc - 0 - (rise_cyc - 6) + (rise_cyc - 6) - rise_cyc + 6 + (rise_cyc - 6), HOLD + 1 + 0);
            idle(4, 1'b0);
        end

        // R6: line-valid high keeps request pending
        tag = "R6"; clear_stats();
        idle(6, 1'b1);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1);
        check_int("R6", pulses, 0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        check_int("R6", pulses, 1);
        check_int("R6", first_pulse - lvfall_cyc, HOLD + 1);
        idle(8, 1'b0);

        // R5: short line-valid glitch during a pending request
        tag = "R5"; clear_stats();
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        check_int("R5", first_pulse - lvfall_cyc, HOLD + 1);
        check_int("R5", pulses, 1);
        idle(8, 1'b0);

        // R7: conversion-complete falls before the strobe
        tag = "R7";
        for (int hi = 1; hi <= HOLD + 2; hi++) begin
            clear_stats();
            for (int i = 0; i < hi; i++) step(1'b1, 1'b0);
            idle(10, 1'b0);
            check_int("R7", pulses, (hi >= HOLD + 2) ? 1 : 0);
        end

        // R9: long quiet period, then a request
        tag = "R9"; clear_stats();
        idle(40, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        check_int("R9", first_pulse - rise_cyc, HOLD + 1);
        check_int("R9", pulses, 1);
        idle(4, 1'b0);

        // R1: reset drops a pending request
        tag = "R1"; clear_stats();
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        rst = 1'b1;
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        rst = 1'b0;
        idle(12, 1'b0);
        check_int("R1", pulses, 0);

        // R8: pseudo-random toggling of both inputs
        tag = "R8";
        lfsr = 16'hACE1;
        d = 1'b0; l = 1'b0;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) d = ~d;
            if (lfsr[7:5] == 3'd0) l = ~l;
            step(d, l);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule